// File: doc/BRIEF.md
# Serial Clock-Calendar Register Target

This block is the register side of a battery-backed clock-calendar. It answers a four-wire serial master and keeps a small address space: seven BCD time and date fields, two four-byte alarm sets, a control byte, a read-only status byte, a charger configuration byte and a window of general-purpose RAM. The counting of seconds, the oscillator, the alarm outputs and the charger circuit belong to other blocks. This block only stores what the master writes and returns it on request.

Each transfer begins when chip enable goes high. The first byte carries the register address in bits 6:0 and the direction in bit 7, where a set bit means write. Every byte after it uses the next address, so a single transfer can stream through the whole time group. Inside the RAM window the address wraps back to the window's first entry instead of leaving it. A write-protect flag in the control byte blocks writes to every address except the control byte itself. The serial pins are sampled by the system clock through synchronizers. A combinational debug port returns any address in parallel. The serial side has no back-pressure: the master sets the pace, and a byte is committed on the rising clock edge that completes it.

Top module: `rtc_spi_slave`

## Requirements
- R1: After reset the control byte (address 0x0F) reads 0x40, so write protect is on. Every time, alarm, charger and RAM byte reads 0x00, and spi_miso is low.
- R2: The first byte after spi_ce rises is the address. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits travel MSB first with the clock idling high. Input is sampled on rising spi_sclk and spi_miso changes after falling spi_sclk. A read transfer never changes the stored bytes, whatever the master shifts in.
- R3: In a write transfer, each data byte after the address goes to the next address in turn. Seven bytes sent after header 0x80 fill addresses 0x00 to 0x06.
- R4: In a read transfer, each data byte returns the next address in turn, starting at the address in the header.
- R5: While control bit 6 is 1, writes to every address other than 0x0F are ignored. The control byte itself stays writable, and writing 0x00 to it lifts the protection.
- R6: Stored bits are limited per field and unused bits read 0. Seconds, minutes and hours keep bits 6:0, so the hours byte holds the 12/24-hour select in bit 6, PM or tens in bit 5 and the BCD hour below. Day of week keeps 2:0, date keeps 5:0, month keeps 4:0, and year keeps all 8 bits. Alarm bytes keep 8 bits and control keeps bits 6, 2, 1 and 0 (mask 0x47).
- R7: Status (0x10) reads 0x00 and ignores writes. The charger byte (0x11) is a full 8-bit register. Addresses 0x12 to 0x1F and those above the RAM window read 0x00 and ignore writes.
- R8: The RAM window starts at 0x20 and holds RAM_WORDS bytes. After its last address the pointer returns to 0x20.
- R9: Dropping spi_ce ends the transfer, discards a partly shifted byte, and makes the next transfer begin with a new address byte.
- R10: spi_miso is low whenever spi_ce is low, during the address byte, and throughout a write transfer.
- R11: dbg_data shows, without a clock delay, the byte a serial read of dbg_addr would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than spi_sclk |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idles high |
| spi_ce | input | 1 | Chip enable, active high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| dbg_addr | input | 7 | Debug read address |
| dbg_data | output | 8 | Byte stored at dbg_addr |

## Verification
A wrong pointer or a wrongly gated write changes stored state that the debug port exposes. The bench compares that port against its own model on every idle clock, starting a few cycles after chip enable drops, so a bad commit is reported at the end of the transfer that caused it. A framing fault such as a lost bit count or a wrong direction bit shows up one byte later as a wrong serial read value, or as spi_miso high during a header or write byte. A broken RAM wrap is exposed by burst transfers that run past the window's last address.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int ADDR_W = 7;
  localparam int CORE_N = 15;
  localparam int WP_BIT = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 7'h0F;
  localparam logic [ADDR_W-1:0] A_STAT = 7'h10;
  localparam logic [ADDR_W-1:0] A_TRKL = 7'h11;
  localparam logic [ADDR_W-1:0] A_RAM  = 7'h20;

  localparam logic [7:0] CTRL_RST  = 8'h40;
  localparam logic [7:0] CTRL_KEEP = 8'h47;

  typedef enum logic {PH_ADDR, PH_DATA} phase_e;

  // bits kept by each time/alarm byte (index = address)
  function automatic logic [7:0] core_mask(input int idx);
    case (idx)
      0, 1, 2: core_mask = 8'h7F;
      3:       core_mask = 8'h07;
      4:       core_mask = 8'h3F;
      5:       core_mask = 8'h1F;
      default: core_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic ce_in,
  input  logic mosi_in,
  output logic ce_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic sclk_s, sclk_p;

  generate
    if (STAGES > 1) begin : g_chain
      logic [STAGES-1:0] sclk_sh, ce_sh, mosi_sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_sh <= '1;
          ce_sh   <= '0;
          mosi_sh <= '0;
        end else begin
          sclk_sh <= {sclk_sh[STAGES-2:0], sclk_in};
          ce_sh   <= {ce_sh[STAGES-2:0], ce_in};
          mosi_sh <= {mosi_sh[STAGES-2:0], mosi_in};
        end
      end
      assign sclk_s = sclk_sh[STAGES-1];
      assign ce_s   = ce_sh[STAGES-1];
      assign mosi_s = mosi_sh[STAGES-1];
    end else begin : g_single
      logic sclk_r, ce_r, mosi_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_r <= 1'b1;
          ce_r   <= 1'b0;
          mosi_r <= 1'b0;
        end else begin
          sclk_r <= sclk_in;
          ce_r   <= ce_in;
          mosi_r <= mosi_in;
        end
      end
      assign sclk_s = sclk_r;
      assign ce_s   = ce_r;
      assign mosi_s = mosi_r;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_p <= 1'b1;
    else        sclk_p <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_p;
  assign sclk_fall = ~sclk_s & sclk_p;
endmodule

// File: rtl/rtc_spi_frame.sv
module rtc_spi_frame
  import rtc_spi_pkg::*;
#(
  parameter int RAM_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              mosi_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic              miso_q
);
  localparam int RAM_LAST_I = 32'h20 + RAM_WORDS - 1;
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_LAST_I);

  phase_e            phase_q;
  logic              rd_q;
  logic [2:0]        bitcnt_q;
  logic [6:0]        shin_q;
  logic [6:0]        txs_q;
  logic [ADDR_W-1:0] ptr_q;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p);
    step = (p == RAM_LAST) ? A_RAM : p + 1'b1;
  endfunction

  function automatic logic in_ram(input logic [ADDR_W-1:0] p);
    in_ram = (p >= A_RAM) && (p <= RAM_LAST);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_ADDR;
      rd_q     <= 1'b0;
      bitcnt_q <= '0;
      shin_q   <= '0;
      txs_q    <= '0;
      ptr_q    <= '0;
      miso_q   <= 1'b0;
    end else if (!ce_s) begin
      phase_q  <= PH_ADDR;
      rd_q     <= 1'b0;
      bitcnt_q <= '0;
      miso_q   <= 1'b0;
    end else begin
      if (sclk_rise) begin
        bitcnt_q <= bitcnt_q + 3'd1;
        shin_q   <= {shin_q[5:0], mosi_s};
        if (bitcnt_q == 3'd7) begin
          if (phase_q == PH_ADDR) begin
            phase_q <= PH_DATA;
            rd_q    <= ~shin_q[6];
            ptr_q   <= {shin_q[5:0], mosi_s};
          end else if (!rd_q) begin
            ptr_q <= step(ptr_q);
          end
        end
      end
      if (sclk_fall && phase_q == PH_DATA && rd_q) begin
        if (bitcnt_q == 3'd0) begin
          miso_q <= rd_data[7];
          txs_q  <= rd_data[6:0];
          ptr_q  <= step(ptr_q);
        end else begin
          miso_q <= txs_q[6];
          txs_q  <= {txs_q[5:0], 1'b0};
        end
      end
    end
  end

  assign ptr     = ptr_q;
  assign wr_en   = ce_s && sclk_rise && (phase_q == PH_DATA) && !rd_q && (bitcnt_q == 3'd7);
  assign wr_data = {shin_q, mosi_s};

  // R9: a low enable clears the framing state
  a_r9_frame_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (bitcnt_q == 3'd0 && phase_q == PH_ADDR));

  // R10: no data bit leaves during the header or a write
  a_r10_quiet_miso: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR || !rd_q) |-> !miso_q);

  // R8: once inside the RAM window the pointer stays there
  a_r8_ram_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && in_ram(ptr_q)) |=> (phase_q != PH_DATA || in_ram(ptr_q)));

  // R3: one commit per completed byte
  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
  import rtc_spi_pkg::*;
#(
  parameter int RAM_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [7:0]        dbg_data
);
  localparam int IW         = $clog2(RAM_WORDS);
  localparam int RAM_LAST_I = 32'h20 + RAM_WORDS - 1;
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_LAST_I);

  logic [CORE_N-1:0][7:0]    core_q;
  logic [RAM_WORDS-1:0][7:0] ram_q;
  logic [7:0]                ctrl_q, trkl_q;
  logic [CORE_N-1:0]         core_we;
  logic [RAM_WORDS-1:0]      ram_we;
  logic                      wp;

  assign wp = ctrl_q[WP_BIT];

  generate
    for (genvar g = 0; g < CORE_N; g++) begin : g_core_we
      assign core_we[g] = wr_en && !wp && (wr_addr == ADDR_W'(g));
    end
    for (genvar g = 0; g < RAM_WORDS; g++) begin : g_ram_we
      assign ram_we[g] = wr_en && !wp && (wr_addr == ADDR_W'(32'h20 + g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      ram_q  <= '0;
      ctrl_q <= CTRL_RST;
      trkl_q <= '0;
    end else begin
      for (int i = 0; i < CORE_N; i++)
        if (core_we[i]) core_q[i] <= wr_data & core_mask(i);
      for (int i = 0; i < RAM_WORDS; i++)
        if (ram_we[i]) ram_q[i] <= wr_data;
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data & CTRL_KEEP;
      if (wr_en && !wp && wr_addr == A_TRKL) trkl_q <= wr_data;
    end
  end

  function automatic logic [7:0] pick(
    input logic [ADDR_W-1:0]       a,
    input logic [CORE_N-1:0][7:0]  c,
    input logic [7:0]              ctl,
    input logic [7:0]              trk,
    input logic [RAM_WORDS-1:0][7:0] r
  );
    logic [ADDR_W-1:0] off;
    off  = a - A_RAM;
    pick = 8'h00;
    if (a < ADDR_W'(CORE_N))           pick = c[a[3:0]];
    else if (a == A_CTRL)              pick = ctl;
    else if (a == A_TRKL)              pick = trk;
    else if (a >= A_RAM && a <= RAM_LAST) pick = r[off[IW-1:0]];
  endfunction

  logic [1:0][ADDR_W-1:0] port_addr;
  logic [1:0][7:0]        port_data;
  assign port_addr[0] = rd_addr;
  assign port_addr[1] = dbg_addr;

  generate
    for (genvar p = 0; p < 2; p++) begin : g_rport
      assign port_data[p] = pick(port_addr[p], core_q, ctrl_q, trkl_q, ram_q);
    end
  endgenerate

  assign rd_data  = port_data[0];
  assign dbg_data = port_data[1];

  // R5: protected writes leave every non-control byte untouched
  a_r5_wp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp && wr_addr != A_CTRL) |=> ($stable(core_q) && $stable(trkl_q) && $stable(ram_q)));

  // R7: the status address never shows a stored value
  a_r7_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == A_STAT) |-> (dbg_data == 8'h00));
endmodule

// File: rtl/rtc_spi_slave.sv
module rtc_spi_slave
  import rtc_spi_pkg::*;
#(
  parameter int RAM_WORDS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_ce,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic [6:0] dbg_addr,
  output logic [7:0] dbg_data
);
  logic              ce_s, mosi_s, sclk_rise, sclk_fall;
  logic [ADDR_W-1:0] ptr;
  logic              wr_en, miso_q;
  logic [7:0]        wr_data, rd_data;

  rtc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_in  (spi_sclk),
    .ce_in    (spi_ce),
    .mosi_in  (spi_mosi),
    .ce_s     (ce_s),
    .mosi_s   (mosi_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall)
  );

  rtc_spi_frame #(.RAM_WORDS(RAM_WORDS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .mosi_s   (mosi_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .miso_q   (miso_q)
  );

  rtc_spi_regs #(.RAM_WORDS(RAM_WORDS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data),
    .dbg_addr(dbg_addr),
    .dbg_data(dbg_data)
  );

  // the pin itself falls with the enable, ahead of the synchronizer
  assign spi_miso = miso_q & spi_ce;
endmodule

// File: tb/rtc_spi_slave_tb_top.sv
module rtc_spi_slave_tb_top;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b1, spi_ce = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso;
  logic [6:0] dbg_addr = '0;
  logic [7:0] dbg_data;

  int tests = 0, fails = 0, idle = 0;
  int mdl [128];

  always #2 clk = ~clk;

  rtc_spi_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_ce(spi_ce),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model of the register space
  function automatic int nextp(input int a);
    return (a == 63) ? 32 : ((a + 1) & 127);
  endfunction

  function automatic void model_wr(input int a, input int d);
    bit prot = mdl[15][6];
    if (a == 15) begin mdl[15] = d & 'h47; return; end
    if (prot) return;
    if (a <= 2)                 mdl[a] = d & 'h7F;
    else if (a == 3)            mdl[a] = d & 'h07;
    else if (a == 4)            mdl[a] = d & 'h3F;
    else if (a == 5)            mdl[a] = d & 'h1F;
    else if (a <= 14)           mdl[a] = d & 'hFF;
    else if (a == 17)           mdl[a] = d & 'hFF;
    else if (a >= 32 && a < 64) mdl[a] = d & 'hFF;
  endfunction

  // every idle clock: debug port against the model (R11)
  always @(negedge clk) begin
    if (!rst_n || spi_ce) idle = 0;
    else idle++;
    if (idle >= 4) check("R11 debug view", dbg_data, mdl[dbg_addr]);
    dbg_addr <= dbg_addr + 7'd1;
  end

  task automatic shift(input int nb, input logic [7:0] tx, output logic [7:0] rx, output bit hi);
    rx = '0; hi = 0;
    for (int i = 7; i >= 8 - nb; i--) begin
      spi_sclk = 1'b0; spi_mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = spi_miso;
      if (spi_miso !== 1'b0) hi = 1;
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic ce_on;
    spi_ce = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic ce_off;
    spi_ce = 1'b0;
    repeat (2 * H) @(negedge clk);
    check("R10 miso idle low", spi_miso, 0);
  endtask

  task automatic wr_txn(input int a, input int q[$]);
    logic [7:0] rx; bit hi; int p;
    ce_on();
    shift(8, 8'(8'h80 | a), rx, hi);
    check("R10 miso low in header", hi, 0);
    p = a;
    foreach (q[i]) begin
      shift(8, 8'(q[i]), rx, hi);
      check("R10 miso low in write", hi, 0);
      model_wr(p, q[i]);
      p = nextp(p);
    end
    ce_off();
  endtask

  task automatic rd_txn(input int a, input int n, input string tag, output int got[$]);
    logic [7:0] rx; bit hi; int p;
    got = {};
    ce_on();
    shift(8, 8'(a & 'h7F), rx, hi);
    check("R10 miso low in header", hi, 0);
    p = a;
    for (int i = 0; i < n; i++) begin
      shift(8, 8'hFF, rx, hi);
      check(tag, rx, mdl[p]);
      got.push_back(rx);
      p = nextp(p);
    end
    ce_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int g[$];
    logic [7:0] rx; bit hi;
    foreach (mdl[i]) mdl[i] = 0;
    mdl[15] = 'h40;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    check("R1 miso after reset", spi_miso, 0);
    rd_txn('h0F, 1, "R1 control reset", g);
    check("R1 write protect set", g[0], 'h40);
    rd_txn('h00, 15, "R1 time and alarm reset", g);

    // R5: protected burst does nothing
    wr_txn('h00, '{'h59, 'h30, 'h72, 'h05, 'h31, 'h12, 'h99});
    rd_txn('h00, 7, "R5 protected burst", g);
    check("R5 seconds unchanged", g[0], 0);
    wr_txn('h0F, '{'h00});
    rd_txn('h0F, 1, "R5 protect cleared", g);
    check("R5 control after clear", g[0], 0);

    // R3/R4 burst write then burst read
    wr_txn('h00, '{'h59, 'h30, 'h72, 'h05, 'h31, 'h12, 'h99});
    rd_txn('h00, 7, "R4 burst read", g);
    check("R3 seconds", g[0], 'h59);
    check("R3 hours 12h PM", g[2], 'h72);
    check("R3 year", g[6], 'h99);
    // R2: the 0xFF clocked in during reads changed nothing
    rd_txn('h00, 1, "R2 read is non-destructive", g);
    check("R2 seconds kept", g[0], 'h59);

    // R6 field widths
    wr_txn('h03, '{'hFF, 'hFF, 'hFF});
    rd_txn('h03, 3, "R6 masked fields", g);
    check("R6 day of week", g[0], 'h07);
    check("R6 date", g[1], 'h3F);
    check("R6 month", g[2], 'h1F);
    wr_txn('h00, '{'hFF, 'hFF, 'hFF});
    rd_txn('h00, 3, "R6 seven-bit fields", g);
    check("R6 hours", g[2], 'h7F);
    wr_txn('h07, '{'hA5, 'h5A});
    rd_txn('h07, 2, "R6 alarm full width", g);

    // R7 status, charger, holes
    wr_txn('h0F, '{'h00, 'hFF, 'hA5});
    rd_txn('h0F, 3, "R7 control status charger", g);
    check("R7 status reads zero", g[1], 0);
    check("R7 charger", g[2], 'hA5);
    wr_txn('h15, '{'h55});
    wr_txn('h45, '{'h66});
    rd_txn('h15, 1, "R7 hole reads zero", g);
    check("R7 hole 0x15", g[0], 0);
    rd_txn('h45, 1, "R7 above RAM reads zero", g);
    check("R7 hole 0x45", g[0], 0);

    // R8 RAM wrap
    wr_txn('h3E, '{'hA1, 'hA2, 'hA3});
    rd_txn('h3F, 2, "R8 wrap read", g);
    check("R8 last RAM byte", g[0], 'hA2);
    check("R8 wrapped to 0x20", g[1], 'hA3);

    // R9 partial byte is dropped
    ce_on();
    shift(8, 8'hA0, rx, hi);
    shift(4, 8'h5A, rx, hi);
    ce_off();
    rd_txn('h20, 1, "R9 partial byte dropped", g);
    check("R9 RAM byte kept", g[0], 'hA3);

    // R5 control stays writable while protected
    wr_txn('h0F, '{'h40});
    wr_txn('h01, '{'h11});
    rd_txn('h01, 1, "R5 protected minutes", g);
    check("R5 minutes kept", g[0], 'h7F);
    wr_txn('h0F, '{'hFF});
    rd_txn('h0F, 1, "R6 control mask", g);
    check("R5 control writable", g[0], 'h47);
    wr_txn('h0F, '{'h00});
    wr_txn('h01, '{'h11});
    rd_txn('h01, 1, "R5 write after clear", g);
    check("R5 minutes written", g[0], 'h11);

    repeat (20) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule